// File: doc/BRIEF.md
# Bit-Serial Systolic Inner-Product Array

This block forms the inner product of a vector of data words and a vector of coefficient words, one bit per clock. Each vector term has its own lane. A lane holds its coefficient bits across a chain of multiplier cells, and the lane's data word streams past them least significant bit first. Every multiplier cell forms one partial-product bit and adds it, with a gated full adder, into a sum bit. That sum bit moves one cell toward the lane output on each clock, while the cell's carry stays in place and is fed back into the same cell.

The lane product streams then pass down a row of latched accumulator cells. Each accumulator cell also keeps its own carry. The last accumulator cell drives the serial result, least significant bit first. Lane k runs k clocks behind lane 0, so that bits of equal weight meet in the accumulator row.

A single frame-start pulse marks bit 0 of lane 0. That pulse is delayed down the lanes along with the data, and it clears every recirculating carry at the boundary between words. Frames may follow each other with no gap, so a new word's partial products start right behind the previous word's. Every data word is padded internally to the frame length. The padding is zeros in unsigned mode and copies of the sign bit in two's-complement mode. In two's-complement mode a control bit on the coefficient's sign cell gives that bit negative weight.

A small sequencer tracks the lane-0 frame position with three states:
- IDLE: no frame is open.
- DATA: the real data bits are arriving.
- GUARD: the padding bits are arriving.

The sequencer has four transitions:
- LAUNCH: IDLE to DATA on frame start.
- EXTEND: DATA to GUARD after the last data bit.
- CLOSE: GUARD to IDLE after the last frame bit.
- RESTART: any state to DATA when frame start is seen.

Top module: `bsip_array`

## Requirements
- R1: While reset is asserted, and after it is released with no frame started, `valid_o`, `first_o` and `result_o` are all 0.
- R2: The frame length is F = DATA_W + COEF_W + clog2(N_TERMS) bits. In unsigned mode, the result equals the sum over k of data word k times coefficient word k, modulo 2^F.
- R3: When `signed_i` is 1 at a lane's start, that lane treats its data word and its coefficient word as two's complement. With every lane signed, the result is the signed sum of products in F-bit two's complement.
- R4: `result_o` carries result bit i during cycle T+N_TERMS+1+i, for i = 0 to F-1, where T is the cycle in which `frame_start_i` is sampled high. `valid_o` is high for exactly those F cycles. `first_o` is high only with bit 0.
- R5: Lane k takes data bit j of a frame in cycle T+k+j. Bit j of the data word sits on `data_i[k]`.
- R6: Any value on `data_i[k]` in cycles T+k+DATA_W to T+k+F-1 has no effect on the result. The block pads the word itself.
- R7: Lane k samples coefficient word k (`coef_i[k*COEF_W +: COEF_W]`) and `signed_i` only in cycle T+k. Values on those inputs in any other cycle have no effect.
- R8: Frames started exactly F cycles apart each give a correct result, with no leakage of sums or carries from one word into the next. Each frame may use a different mode.
- R9: When frames are more than F cycles apart, `valid_o` and `first_o` are low between the result words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Marks bit 0 of a new frame on lane 0 |
| signed_i | input | 1 | Two's-complement mode, sampled per lane at that lane's start |
| data_i | input | N_TERMS | One serial data bit per lane; lane k is skewed by k cycles |
| coef_i | input | N_TERMS*COEF_W | Coefficient words; word k is sampled at lane k's start |
| result_o | output | 1 | Serial inner-product bit, LSB first |
| valid_o | output | 1 | High while `result_o` carries a bit of a result word |
| first_o | output | 1 | High with bit 0 of each result word |

## Verification
The bench builds the array with three lanes, 4-bit data and 5-bit coefficients, which gives an 11-bit frame. With these widths the full-range extremes can be driven on every lane. In unsigned mode that is all-ones times all-ones. In signed mode it is the most negative data word times the most negative coefficient. Both extremes land close to the edge of the guard band. The odd lane count makes clog2 round up. The different data and coefficient widths mean that swapping the two roles would give wrong timing. Short frames allow back-to-back runs with alternating modes, junk in the padding slots, and gaps between frames, all within a few hundred cycles.

// File: rtl/bsip_pkg.sv
package bsip_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DATA  = 2'd1,
        SEQ_GUARD = 2'd2
    } seq_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/bsip_seq.sv
module bsip_seq
    import bsip_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic in_data_o,
    output logic in_frame_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(FRAME_W - 1);
    localparam seq_state_e AFTER_START = (DATA_W > 1) ? SEQ_DATA : SEQ_GUARD;

    seq_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (start_i) begin
            state_n = AFTER_START;
            cnt_n   = CNT_W'(1);
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    cnt_n = '0;
                end
                SEQ_DATA: begin
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == LAST_DATA) state_n = SEQ_GUARD;
                end
                SEQ_GUARD: begin
                    if (cnt_q == LAST_FRAME) begin
                        state_n = SEQ_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_n = SEQ_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_comb begin
        in_data_o  = start_i | (state_q == SEQ_DATA);
        in_frame_o = start_i | (state_q != SEQ_IDLE);
    end

endmodule

// File: rtl/bsip_mac_chain.sv
module bsip_mac_chain
    import bsip_pkg::*;
#(
    parameter int COEF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_i,
    input  logic              fs_i,
    input  logic              in_data_i,
    input  logic [COEF_W-1:0] coef_i,
    input  logic              signed_i,
    output logic              prod_o
);
    localparam int SIGN_CELL = COEF_W - 1;

    logic [COEF_W-1:0] w_q, w_cur;
    logic              sgn_q, sgn_cur;
    logic              xlast_q, x_eff;
    logic [COEF_W-1:0] s_q, c_q, s_n, c_n;

    assign w_cur   = fs_i ? coef_i : w_q;
    assign sgn_cur = fs_i ? signed_i : sgn_q;
    assign x_eff   = in_data_i ? x_i : (sgn_cur & xlast_q);

    for (genvar j = 0; j < COEF_W; j++) begin : g_cell
        logic ctrl, g, sin, cin;
        assign ctrl = (j == SIGN_CELL) ? sgn_cur : 1'b0;
        assign g    = (x_eff & w_cur[j]) ^ ctrl;
        if (j == SIGN_CELL) begin : g_top
            assign sin = 1'b0;
        end else begin : g_mid
            assign sin = fs_i ? 1'b0 : s_q[j+1];
        end
        assign cin    = fs_i ? ctrl : c_q[j];
        assign s_n[j] = g ^ sin ^ cin;
        assign c_n[j] = maj3(g, sin, cin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q     <= '0;
            sgn_q   <= 1'b0;
            xlast_q <= 1'b0;
            s_q     <= '0;
            c_q     <= '0;
        end else begin
            w_q   <= w_cur;
            sgn_q <= sgn_cur;
            if (in_data_i) xlast_q <= x_i;
            s_q   <= s_n;
            c_q   <= c_n;
        end
    end

    assign prod_o = s_q[0];

endmodule

// File: rtl/bsip_acc_row.sv
module bsip_acc_row
    import bsip_pkg::*;
#(
    parameter int N_TERMS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TERMS-1:0] prod_i,
    input  logic [N_TERMS-1:0] clr_i,
    output logic               sum_o
);
    logic [N_TERMS-1:0] acc_q, cr_q, acc_n, cr_n;

    for (genvar k = 0; k < N_TERMS; k++) begin : g_acc
        logic prev, cin;
        if (k == 0) begin : g_head
            assign prev = 1'b0;
        end else begin : g_tail
            assign prev = acc_q[k-1];
        end
        assign cin      = clr_i[k] ? 1'b0 : cr_q[k];
        assign acc_n[k] = prod_i[k] ^ prev ^ cin;
        assign cr_n[k]  = maj3(prod_i[k], prev, cin);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cr_q  <= '0;
        end else begin
            acc_q <= acc_n;
            cr_q  <= cr_n;
        end
    end

    assign sum_o = acc_q[N_TERMS-1];

endmodule

// File: rtl/bsip_array.sv
module bsip_array
    import bsip_pkg::*;
#(
    parameter int N_TERMS = 4,
    parameter int DATA_W  = 8,
    parameter int COEF_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start_i,
    input  logic                      signed_i,
    input  logic [N_TERMS-1:0]        data_i,
    input  logic [N_TERMS*COEF_W-1:0] coef_i,
    output logic                      result_o,
    output logic                      valid_o,
    output logic                      first_o
);
    localparam int GUARD_W = $clog2(N_TERMS);
    localparam int FRAME_W = DATA_W + COEF_W + GUARD_W;

    logic               in_data0, in_frame0;
    logic [N_TERMS-1:0] fs_lane, dat_lane, fs_q, prod;
    logic [N_TERMS-2:0] dat_q;
    logic [N_TERMS:0]   vld_q, fst_q;

    bsip_seq #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (frame_start_i),
        .in_data_o (in_data0),
        .in_frame_o(in_frame0)
    );

    assign fs_lane[0]  = frame_start_i;
    assign dat_lane[0] = in_data0;
    for (genvar k = 1; k < N_TERMS; k++) begin : g_skew
        assign fs_lane[k]  = fs_q[k-1];
        assign dat_lane[k] = dat_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q  <= '0;
            dat_q <= '0;
            vld_q <= '0;
            fst_q <= '0;
        end else begin
            fs_q  <= fs_lane;
            dat_q <= dat_lane[N_TERMS-2:0];
            vld_q <= {vld_q[N_TERMS-1:0], in_frame0};
            fst_q <= {fst_q[N_TERMS-1:0], frame_start_i};
        end
    end

    for (genvar k = 0; k < N_TERMS; k++) begin : g_lane
        bsip_mac_chain #(.COEF_W(COEF_W)) u_mac (
            .clk      (clk),
            .rst_n    (rst_n),
            .x_i      (data_i[k]),
            .fs_i     (fs_lane[k]),
            .in_data_i(dat_lane[k]),
            .coef_i   (coef_i[k*COEF_W +: COEF_W]),
            .signed_i (signed_i),
            .prod_o   (prod[k])
        );
    end

    bsip_acc_row #(.N_TERMS(N_TERMS)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .prod_i(prod),
        .clr_i (fs_q),
        .sum_o (result_o)
    );

    assign valid_o = vld_q[N_TERMS];
    assign first_o = fst_q[N_TERMS];

endmodule

// File: rtl/bsip_array_chk.sv
module bsip_array_chk #(
    parameter int N_TERMS = 4,
    parameter int FRAME_W = 18
) (
    input logic clk,
    input logic rst_n,
    input logic frame_start_i,
    input logic valid_o,
    input logic first_o
);
    localparam int LAT   = N_TERMS + 1;
    localparam int LC_W  = $clog2(LAT + 2);
    localparam int RUN_W = $clog2(FRAME_W + 2);

    logic [LC_W-1:0]  since_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            run_q   <= '0;
        end else begin
            if (frame_start_i)
                since_q <= LC_W'(1);
            else if (since_q != '0 && since_q <= LC_W'(LAT))
                since_q <= since_q + 1'b1;
            if (first_o)
                run_q <= RUN_W'(1);
            else if (valid_o)
                run_q <= run_q + 1'b1;
            else
                run_q <= '0;
        end
    end

    // R4
    r4_first_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_o |-> valid_o);

    // R4
    r4_rise_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> first_o);

    // R4
    r4_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (first_o || (run_q < RUN_W'(FRAME_W))));

    // R4
    r4_first_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == LC_W'(LAT)) |-> first_o);

endmodule

bind bsip_array bsip_array_chk #(.N_TERMS(N_TERMS), .FRAME_W(FRAME_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start_i),
    .valid_o      (valid_o),
    .first_o      (first_o)
);

// File: tb/tb_bsip_array.sv
`timescale 1ns/1ps
module tb_bsip_array;
    localparam int N = 3;
    localparam int B = 4;
    localparam int C = 5;
    localparam int F = B + C + $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_start_i = 1'b0;
    logic           signed_i = 1'b0;
    logic [N-1:0]   data_i = '0;
    logic [N*C-1:0] coef_i = '0;
    logic           result_o, valid_o, first_o;

    int n_checks = 0;
    int n_fail   = 0;

    int fx  [0:3][0:N-1];
    int fw  [0:3][0:N-1];
    bit fsg [0:3];

    always #4 clk = ~clk;

    bsip_array #(.N_TERMS(N), .DATA_W(B), .COEF_W(C)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i), .signed_i(signed_i),
        .data_i(data_i), .coef_i(coef_i), .result_o(result_o), .valid_o(valid_o),
        .first_o(first_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint expv(input int fi);
        longint acc = 0;
        for (int k = 0; k < N; k++) begin
            longint sx = fx[fi][k];
            longint sw = fw[fi][k];
            if (fsg[fi]) begin
                if (sx >= (1 << (B-1))) sx -= (1 << B);
                if (sw >= (1 << (C-1))) sw -= (1 << C);
            end
            acc += sx * sw;
        end
        return acc & ((64'd1 << F) - 1);
    endfunction

    // Drives nfr frames spaced 'spacing' cycles apart, skewing lane k by k cycles.
    task automatic run_stream(input string req, input int nfr, input int spacing, input bit junk);
        logic [F-1:0] got [0:3];
        int total = (nfr - 1) * spacing + F + N + 3;
        int bad_valid = 0, bad_first = 0, bad_idle = 0;
        for (int c = 0; c < total; c++) begin
            bit any;
            @(negedge clk);
            any = 0;
            for (int fi = 0; fi < nfr; fi++) begin
                int sig = c - fi * spacing - N - 1;
                if (sig >= 0 && sig < F) begin
                    any = 1;
                    got[fi][sig] = result_o;
                    if (valid_o !== 1'b1) bad_valid++;
                    if (first_o !== (sig == 0)) bad_first++;
                end
            end
            if (!any && (valid_o !== 1'b0 || first_o !== 1'b0)) bad_idle++;
            frame_start_i = 1'b0;
            signed_i = junk ? 1'($urandom) : 1'b0;
            coef_i   = junk ? (N*C)'({$urandom, $urandom}) : '0;
            data_i   = junk ? N'($urandom) : '0;
            for (int fi = 0; fi < nfr; fi++) begin
                int rel = c - fi * spacing;
                if (rel == 0) frame_start_i = 1'b1;
                if (rel >= 0 && rel < N) signed_i = fsg[fi];
                for (int k = 0; k < N; k++) begin
                    int t = rel - k;
                    if (rel == k) coef_i[k*C +: C] = C'(fw[fi][k]);
                    if (t >= 0 && t < B) data_i[k] = fx[fi][k][t];
                    else if (t >= B && t < F) data_i[k] = junk ? 1'($urandom) : 1'b0;
                end
            end
        end
        for (int fi = 0; fi < nfr; fi++)
            check(longint'(got[fi]) == expv(fi), {req, " result"}, longint'(got[fi]), expv(fi));
        check(bad_valid == 0, "R4 valid window", bad_valid, 0);
        check(bad_first == 0, "R4 first flag", bad_first, 0);
        check(bad_idle == 0, "R9 idle outputs", bad_idle, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(valid_o == 1'b0, "R1 valid", valid_o, 0);
        check(first_o == 1'b0, "R1 first", first_o, 0);
        check(result_o == 1'b0, "R1 result", result_o, 0);
    endtask

    task automatic t_unsigned;
        fx[0] = '{15, 3, 9};  fw[0] = '{31, 17, 6};  fsg[0] = 0;
        run_stream("R2 R5 unsigned", 1, F, 0);
        fx[0] = '{15, 15, 15}; fw[0] = '{31, 31, 31}; fsg[0] = 0;
        run_stream("R2 unsigned max", 1, F, 0);
    endtask

    task automatic t_signed;
        fx[0] = '{8, 7, 13};  fw[0] = '{5, 20, 31}; fsg[0] = 1;
        run_stream("R3 signed mix", 1, F, 0);
        fx[0] = '{8, 8, 8};   fw[0] = '{16, 16, 16}; fsg[0] = 1;
        run_stream("R3 signed extreme", 1, F, 0);
    endtask

    task automatic t_back2back;
        fx[0] = '{5, 12, 1};  fw[0] = '{9, 2, 30};  fsg[0] = 0;
        fx[1] = '{9, 15, 4};  fw[1] = '{16, 31, 3}; fsg[1] = 1;
        fx[2] = '{15, 15, 15}; fw[2] = '{31, 31, 31}; fsg[2] = 0;
        fx[3] = '{8, 1, 7};   fw[3] = '{1, 16, 15}; fsg[3] = 1;
        run_stream("R8 back-to-back", 4, F, 0);
    endtask

    task automatic t_junk;
        fx[0] = '{11, 6, 2};  fw[0] = '{7, 25, 19}; fsg[0] = 1;
        fx[1] = '{3, 14, 10}; fw[1] = '{28, 4, 11}; fsg[1] = 0;
        run_stream("R6 R7 junk outside windows", 2, F, 1);
    endtask

    task automatic t_gap;
        fx[0] = '{4, 9, 13};  fw[0] = '{12, 3, 22}; fsg[0] = 0;
        fx[1] = '{14, 2, 8};  fw[1] = '{17, 9, 1};  fsg[1] = 1;
        run_stream("R9 spaced frames", 2, F + 5, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_unsigned;
        t_signed;
        t_back2back;
        t_junk;
        t_gap;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule